// File: doc/BRIEF.md
# Two-Pin Software-Defined I/O Controller

This block drives two general-purpose pins from fields of one 32-bit control word. Software sets each pin's direction and output level through a register write port. A pin in input mode is read back through the same data field. A pin in input mode can also raise an interrupt on a rising edge of its level. Pin 0 can instead carry a watchdog indication. Its active level then follows the pin's data bit.

The block has two reset scopes. Power-on reset clears everything. A self-clearing request bit in the control word holds an internal reset for a fixed number of cycles. That internal reset clears the interrupt enables, the watchdog mode and the interrupt causes, and returns the data bits to their configured defaults. It leaves pin direction alone. A configuration-load strobe sets the direction bits and the data defaults after power-on. Pin inputs pass through a synchroniser before any use. Rising-edge causes stay latched until software clears them by writing ones.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: Control-word field positions are: interrupt enable at bit 16 (pin 0) and bit 17 (pin 1), data at bits 18/19, watchdog mode at bit 21, direction at bits 22/23, reset request at bit 26. A written field reads back its written value, except as R3 and R8 state. After power-on the word reads 0.
- R2: A direction bit of 0 makes the pin an input (`pin_oe` low). A direction bit of 1 makes it an output (`pin_oe` high), driving the stored data bit on `pin_out` unless R7 applies.
- R3: For a pin in input mode, its data field reads back the pin level after the input synchroniser, not the stored bit.
- R4: A rising edge of a synchronised input, on a pin that is in input mode with its enable bit set, sets that pin's bit in `cause` (bit 0 = pin 0). `irq` is the OR of the `cause` bits.
- R5: No cause is set for a pin whose enable bit is clear or whose direction is output.
- R6: A `cause_clr` bit of 1 clears the matching cause bit. A `cause_clr` bit of 0 leaves it set.
- R7: With watchdog mode set and pin 0 in output mode, `pin_out[0]` equals data bit 18 while `wdog_event` is high and its inverse while `wdog_event` is low.
- R8: A write with bit 26 set starts an internal reset that lasts RST_PULSE_CYCLES cycles (default 8). During that time `glb_rst_req` and bit 26 read 1, and both read 0 afterwards. The reset clears the enables, the watchdog mode and the causes, and sets the data bits to the configured defaults. The other fields of that write are not applied, except direction.
- R9: Direction bits are unchanged by the internal reset. Only power-on, configuration load or a register write changes them.
- R10: A `cfg_load` pulse loads `cfg_dir` into the direction bits and `cfg_data` into both the data bits and the data defaults used by R8.
- R11: Reserved bits 25:24 and all unlisted bits read 0 whatever is written.
- R12: A falling edge of an input does not set a cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_dir | input | 2 | Direction values loaded by the strobe |
| cfg_data | input | 2 | Data values and data defaults loaded by the strobe |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback |
| cause_clr | input | 2 | Write-one-to-clear for the interrupt causes |
| cause | output | 2 | Latched interrupt causes |
| irq | output | 1 | Interrupt request |
| wdog_event | input | 1 | Watchdog status shown on pin 0 in watchdog mode |
| pin_in | input | 2 | Pin input levels |
| pin_out | output | 2 | Pin output levels |
| pin_oe | output | 2 | Pin output enables |
| glb_rst_req | output | 1 | High while the internal reset is held |

## Verification
The bench uses the defaults RST_PULSE_CYCLES=8 and SYNC_STAGES=2. The reset pulse is therefore short enough to sample `glb_rst_req` and bit 26 on every cycle of the pulse and on the first cycle after it. The two-stage synchroniser puts a cause bit one cycle behind the synchronised edge. Every edge test can then wait a fixed four cycles and still see the correct cause state, including after a falling edge or a blocked edge.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int NPINS   = 2;
  localparam int REG_W   = 32;
  localparam int BIT_IEN = 16;
  localparam int BIT_DAT = 18;
  localparam int BIT_WDE = 21;
  localparam int BIT_DIR = 22;
  localparam int BIT_RST = 26;

  typedef struct packed {
    logic [NPINS-1:0] ien;
    logic [NPINS-1:0] dat;
    logic             wde;
  } soft_fields_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] sync,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-2:0], pin_in[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign sync[i] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync;
  end

  assign rise = sync & ~prev_q;
endmodule

// File: rtl/gpio_rst_pulse.sv
module gpio_rst_pulse #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start && cnt_q == '0) cnt_d = CNT_W'(CYCLES);
    else if (cnt_q != '0)     cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R8: the pulse only begins after a request
  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start));

  // R8: the pulse ends once the count runs out
  p_pulse_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_q == CNT_W'(1)) |=> !active);
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv #(
  parameter int N        = 2,
  parameter int WDOG_PIN = 0
) (
  input  logic [N-1:0] dir,
  input  logic [N-1:0] dat,
  input  logic         wde,
  input  logic         wdog_event,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  for (genvar i = 0; i < N; i++) begin : g_drv
    if (i == WDOG_PIN) begin : g_wdog
      always_comb begin
        if (wde) pin_out[i] = wdog_event ? dat[i] : ~dat[i];
        else     pin_out[i] = dat[i];
      end
    end else begin : g_plain
      always_comb pin_out[i] = dat[i];
    end
  end

  assign pin_oe = dir;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int RST_PULSE_CYCLES = 8,
  parameter int SYNC_STAGES      = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cfg_load,
  input  logic [NPINS-1:0] cfg_dir,
  input  logic [NPINS-1:0] cfg_data,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NPINS-1:0] cause_clr,
  output logic [NPINS-1:0] cause,
  output logic             irq,
  input  logic             wdog_event,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             glb_rst_req
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic [NPINS-1:0] dir_q, dir_d;
  logic [NPINS-1:0] dflt_q, dflt_d;
  soft_fields_t     soft_q, soft_d;
  logic [NPINS-1:0] cause_q, cause_d;
  logic [NPINS-1:0] sync, rise;
  logic             rst_active;
  logic             wr_ok;
  logic             start;

  wire unused_wbits = ^{reg_wdata[15:0], reg_wdata[20], reg_wdata[25:24], reg_wdata[31:27]};

  assign wr_ok = reg_wr && !rst_active;
  assign start = wr_ok && reg_wdata[BIT_RST];

  gpio_in_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync(sync), .rise(rise));

  gpio_rst_pulse #(.CYCLES(RST_PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(start), .active(rst_active));

  gpio_pin_drv #(.N(NPINS), .WDOG_PIN(0)) u_drv (
    .dir(dir_q), .dat(soft_q.dat), .wde(soft_q.wde), .wdog_event(wdog_event),
    .pin_out(pin_out), .pin_oe(pin_oe));

  // next state: power-on-only fields
  always_comb begin
    dir_d  = dir_q;
    dflt_d = dflt_q;
    if (cfg_load) begin
      dir_d  = cfg_dir;
      dflt_d = cfg_data;
    end else if (wr_ok) begin
      dir_d = reg_wdata[BIT_DIR +: NPINS];
    end
  end

  // next state: fields cleared by the internal reset
  always_comb begin
    soft_d = soft_q;
    if (rst_active) begin
      soft_d.ien = '0;
      soft_d.dat = dflt_q;
      soft_d.wde = 1'b0;
    end else if (cfg_load) begin
      soft_d.dat = cfg_data;
    end else if (wr_ok && !reg_wdata[BIT_RST]) begin
      soft_d.ien = reg_wdata[BIT_IEN +: NPINS];
      soft_d.dat = reg_wdata[BIT_DAT +: NPINS];
      soft_d.wde = reg_wdata[BIT_WDE];
    end
  end

  always_comb begin
    if (rst_active) cause_d = '0;
    else            cause_d = (cause_q & ~cause_clr) | (rise & soft_q.ien & ~dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dflt_q  <= '0;
      soft_q  <= '0;
      cause_q <= '0;
    end else begin
      dir_q   <= dir_d;
      dflt_q  <= dflt_d;
      soft_q  <= soft_d;
      cause_q <= cause_d;
    end
  end

  always_comb begin
    reg_rdata                     = '0;
    reg_rdata[BIT_IEN +: NPINS]   = soft_q.ien;
    reg_rdata[BIT_DAT +: NPINS]   = (dir_q & soft_q.dat) | (~dir_q & sync);
    reg_rdata[BIT_WDE]            = soft_q.wde;
    reg_rdata[BIT_DIR +: NPINS]   = dir_q;
    reg_rdata[BIT_RST]            = rst_active;
  end

  assign cause       = cause_q;
  assign irq         = |cause_q;
  assign glb_rst_req = rst_active;

  // R9: direction holds through the internal reset
  p_dir_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_active && !cfg_load) |=> $stable(dir_q));

  // R4/R5: pin 0 cause only rises when enabled in input mode
  p_cause0_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q[0]) |-> $past(soft_q.ien[0] && !dir_q[0]));

  // R4/R5: pin 1 cause only rises when enabled in input mode
  p_cause1_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q[1]) |-> $past(soft_q.ien[1] && !dir_q[1]));

  // R6: a cause stays set until it is cleared
  p_cause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q[0] && !cause_clr[0] && !rst_active) |=> cause_q[0]);

  // R8: the internal reset empties the causes
  p_cause_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_active) |-> (cause_q == '0));
endmodule

// File: tb/gpio_pin_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_tb;
  logic        clk = 1'b0;
  logic        por_n;
  logic        cfg_load;
  logic [1:0]  cfg_dir, cfg_data;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [1:0]  cause_clr, cause;
  logic        irq, wdog_event, glb_rst_req;
  logic [1:0]  pin_in, pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_pin_ctrl u_dut (
    .clk(clk), .por_n(por_n), .cfg_load(cfg_load), .cfg_dir(cfg_dir), .cfg_data(cfg_data),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cause_clr(cause_clr), .cause(cause), .irq(irq), .wdog_event(wdog_event),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .glb_rst_req(glb_rst_req));

  // {wdata[69:38], pin_in[37:36], exp_rdata[35:4], exp_oe[3:2], exp_out[1:0]}
  localparam logic [69:0] VEC [6] = '{
    {32'h00C0_0000, 2'b11, 32'h00C0_0000, 2'b11, 2'b00},
    {32'h00CC_0000, 2'b00, 32'h00CC_0000, 2'b11, 2'b11},
    {32'h0044_0000, 2'b10, 32'h004C_0000, 2'b01, 2'b01},
    {32'h0000_0000, 2'b01, 32'h0004_0000, 2'b00, 2'b00},
    {32'hFBFF_FFFF, 2'b00, 32'h00EF_0000, 2'b11, 2'b10},
    {32'h0308_0000, 2'b10, 32'h0008_0000, 2'b00, 2'b10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clr(input logic [1:0] m);
    cause_clr = m;
    @(negedge clk);
    cause_clr = '0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    por_n = 1'b0; cfg_load = 1'b0; cfg_dir = '0; cfg_data = '0;
    reg_wr = 1'b0; reg_wdata = '0; cause_clr = '0; wdog_event = 1'b0; pin_in = '0;
    tick(3);
    por_n = 1'b1;
    tick(3);
    chk("R1 reset rdata", reg_rdata, 32'h0);
    chk("R2 reset oe", {30'b0, pin_oe}, 32'h0);
    chk("R4 reset irq", {31'b0, irq}, 32'h0);
    chk("R8 reset glb", {31'b0, glb_rst_req}, 32'h0);

    // R1 R2 R3 R7 R11 table walk
    for (int i = 0; i < 6; i++) begin
      pin_in = VEC[i][37:36];
      wr(VEC[i][69:38]);
      tick(3);
      chk("R1/R3/R11 table rdata", reg_rdata, VEC[i][35:4]);
      chk("R2 table oe", {30'b0, pin_oe}, {30'b0, VEC[i][3:2]});
      chk("R2/R7 table out", {30'b0, pin_out}, {30'b0, VEC[i][1:0]});
    end

    // R10 configuration load
    cfg_dir = 2'b01; cfg_data = 2'b01; cfg_load = 1'b1;
    tick(1);
    cfg_load = 1'b0;
    tick(1);
    chk("R10 cfg rdata", reg_rdata, 32'h004C_0000);
    chk("R10 cfg oe", {30'b0, pin_oe}, 32'h1);
    chk("R10 cfg out", {30'b0, pin_out}, 32'h1);

    // R4 R6 R12 interrupt causes
    pin_in = 2'b00;
    wr(32'h0003_0000);
    tick(4);
    chk("R4 idle cause", {30'b0, cause}, 32'h0);
    pin_in = 2'b01;
    tick(4);
    chk("R4 rise cause", {30'b0, cause}, 32'h1);
    chk("R4 irq", {31'b0, irq}, 32'h1);
    clr(2'b10);
    chk("R6 clear other bit keeps", {30'b0, cause}, 32'h1);
    clr(2'b01);
    chk("R6 clear", {30'b0, cause}, 32'h0);
    chk("R6 irq low", {31'b0, irq}, 32'h0);
    pin_in = 2'b00;
    tick(4);
    chk("R12 fall no cause", {30'b0, cause}, 32'h0);

    // R5 blocked detection
    wr(32'h0041_0000);
    tick(3);
    pin_in = 2'b11;
    tick(4);
    chk("R5 blocked cause", {30'b0, cause}, 32'h0);

    // R7 watchdog
    wr(32'h0064_0000);
    wdog_event = 1'b1;
    tick(1);
    chk("R7 wdog high active", {31'b0, pin_out[0]}, 32'h1);
    chk("R7 oe", {31'b0, pin_oe[0]}, 32'h1);
    wdog_event = 1'b0;
    tick(1);
    chk("R7 wdog idle", {31'b0, pin_out[0]}, 32'h0);
    wr(32'h0060_0000);
    chk("R7 low pol idle", {31'b0, pin_out[0]}, 32'h1);
    wdog_event = 1'b1;
    tick(1);
    chk("R7 low pol active", {31'b0, pin_out[0]}, 32'h0);
    wdog_event = 1'b0;

    // R8 R9 internal reset
    pin_in = 2'b00;
    wr(32'h0003_0000);
    tick(3);
    pin_in = 2'b10;
    tick(4);
    chk("R4 pin1 cause", {30'b0, cause}, 32'h2);
    reg_wr = 1'b1; reg_wdata = 32'h04C0_0000;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    for (int k = 0; k < 8; k++) begin
      chk("R8 pulse glb", {31'b0, glb_rst_req}, 32'h1);
      chk("R8 pulse bit26", {31'b0, reg_rdata[26]}, 32'h1);
      tick(1);
    end
    chk("R8 pulse over", {31'b0, glb_rst_req}, 32'h0);
    chk("R8/R9 after rdata", reg_rdata, 32'h00C4_0000);
    chk("R8 cause flushed", {30'b0, cause}, 32'h0);
    chk("R9 oe kept", {30'b0, pin_oe}, 32'h3);

    done = 1'b1;
    report();
  end
endmodule